// File: doc/BRIEF.md
# Shadow-Buffered Timekeeping Register File

This block is the register-side front end of a calendar clock. It sits between a byte-wide host bus engine and a counting core. The bus engine reports a transaction start, an address load, a written byte, an acknowledge for that byte, and a read advance. The block answers with read data from a 64-byte space. Indices 00h to 06h hold the seven time and date bytes: seconds, minutes, hours, weekday, day of month, month and year. Index 07h is a control byte, and 08h to 3Fh are 56 bytes of general storage.

At every transaction start, the block copies the live time bytes from the core into a user buffer. Reads in that transaction are served from this frozen copy, so a burst of reads sees one consistent instant while the core keeps counting. A written byte first lands in a pending holder, and in the buffer when it targets a time byte. It reaches the core, the control byte or the storage only in the cycle the bus acknowledges it. The block also contains the sub-second prescaler. The prescaler counts pulses of a 32.768 kHz enable and issues one tick per second. Committing the seconds byte clears the prescaler. After a seconds write, the host has one second to finish writing the remaining time bytes before the next carry.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the pointer is 00h, all seven buffer bytes read 00h, the control byte reads 00h, `core_wr_en` is low and no tick is issued until the enable has pulsed 2^DIV_W times.
- R2: A cycle with `bus_start` high loads all seven buffer bytes from `core_time`, where byte i is `core_time[8i+7:8i]`. Reads from indices 00h–06h then return those loaded values, even if `core_time` changes afterwards.
- R3: `core_wr_en` is high only in a cycle where `bus_ack` is high and a written time byte is pending. In that cycle `core_wr_idx` equals the byte's index and `core_wr_data` equals the written value. A time byte written with `bus_wr` reads back from the buffer on the very next cycle.
- R4: When index 00h is committed, the prescaler is cleared. The next `sec_tick` comes in exactly the 2^DIV_W-th cycle after the commit cycle, given that the enable is high every cycle.
- R5: If a tick would fall in the same cycle as a seconds commit, that tick is not issued.
- R6: With the enable high, `sec_tick` pulses for one cycle once every 2^DIV_W enabled cycles, and is low at all other times.
- R7: The control byte at 07h stores only bits 7, 4, 1 and 0 of the value written. Bits 6, 5, 3 and 2 always read 0, so writing FFh reads back 93h.
- R8: Indices 08h–3Fh store written bytes and return them on read. Commits to these indices and to 07h never raise `core_wr_en`.
- R9: The pointer advances by one after each `bus_rd` and after each acknowledged write, and it wraps from 3Fh to 00h.
- R10: `bus_addr_vld` loads the pointer from `bus_addr`. This takes priority over any advance in the same cycle.
- R11: An acknowledge with no pending written byte commits nothing and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| bus_start | input | 1 | Transaction start; loads the time buffer |
| bus_addr_vld | input | 1 | Load the pointer from bus_addr |
| bus_addr | input | ADDR_W | Register index to load |
| bus_wr | input | 1 | Byte written at the pointer |
| bus_wdata | input | 8 | Written byte |
| bus_ack | input | 1 | Acknowledge of the pending written byte |
| bus_rd | input | 1 | Read done; advance the pointer |
| bus_rdata | output | 8 | Byte at the pointer |
| core_time | input | 56 | Live time bytes from the counting core |
| core_wr_en | output | 1 | Commit strobe toward the core |
| core_wr_idx | output | 3 | Index of the time byte being committed |
| core_wr_data | output | 8 | Value being committed |
| sec_tick | output | 1 | One-second tick toward the core |

## Verification
A buffer that loads at the wrong time shows up as a mismatch on `bus_rdata`. This is seen in the first read after `core_time` moves within a transaction. A stray pending flag or pointer slip appears in the same cycle as a wrong `core_wr_en` or a shifted read address. A prescaler that is out of phase is caught at the next expected tick, no more than 2^DIV_W cycles later. The coincident commit-and-tick case is forced on purpose, so the dropped tick is seen in that cycle.

// File: rtl/rtc_rf_pkg.sv
package rtc_rf_pkg;
  localparam int TIME_BYTES = 7;
  localparam int CTRL_IDX   = 7;
  localparam int RAM_BASE   = 8;
  localparam int TIDX_W     = 3;
  localparam logic [7:0] CTRL_KEEP = 8'h93;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             clr,
  output logic             tick,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (osc_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick  = osc_en & (&cnt_q) & ~clr;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_rf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    snap,
  input  logic [TIME_BYTES*8-1:0] live,
  input  logic                    wr_en,
  input  logic [TIDX_W-1:0]       wr_idx,
  input  byte_t                   wr_data,
  input  logic [TIDX_W-1:0]       rd_idx,
  output byte_t                   rd_data,
  output logic [TIME_BYTES*8-1:0] buf_o
);
  byte_t buf_q [TIME_BYTES];

  for (genvar i = 0; i < TIME_BYTES; i++) begin : g_byte
    byte_t nxt;
    always_comb begin
      nxt = buf_q[i];
      if (snap)                                       nxt = live[8*i +: 8];
      else if (wr_en && (wr_idx == TIDX_W'(i)))       nxt = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_q[i] <= '0;
      else        buf_q[i] <= nxt;
    end
    assign buf_o[8*i +: 8] = buf_q[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < TIME_BYTES; i++)
      if (rd_idx == TIDX_W'(i)) rd_data = buf_q[i];
  end
endmodule

// File: rtl/rtc_store.sv
module rtc_store
  import rtc_rf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output byte_t             rd_data
);
  localparam int DEPTH = (1 << ADDR_W) - RAM_BASE;

  byte_t ctrl_q, ctrl_d;
  byte_t mem [DEPTH];
  logic  ctrl_hit, mem_we;
  logic [ADDR_W-1:0] widx, ridx;

  assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_IDX));
  assign mem_we   = wr_en && (wr_addr >= ADDR_W'(RAM_BASE));
  assign widx     = wr_addr - ADDR_W'(RAM_BASE);
  assign ridx     = rd_addr - ADDR_W'(RAM_BASE);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_hit) ctrl_d = wr_data & CTRL_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[widx] <= wr_data;
  end

  assign rd_data = (rd_addr == ADDR_W'(CTRL_IDX)) ? ctrl_q : mem[ridx];
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_rf_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              bus_start,
  input  logic              bus_addr_vld,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic [55:0]       core_time,
  output logic              core_wr_en,
  output logic [2:0]        core_wr_idx,
  output logic [7:0]        core_wr_data,
  output logic              sec_tick
);
  logic [ADDR_W-1:0] ptr_q, ptr_d, pend_addr_q, pend_addr_d;
  byte_t             pend_data_q, pend_data_d;
  logic              pend_vld_q, pend_vld_d;
  logic              commit, pend_is_time, ptr_is_time, div_clr, buf_we;
  byte_t             buf_rd, store_rd;
  logic [TIME_BYTES*8-1:0] shad_flat;
  logic [DIV_W-1:0]  div_cnt;

  assign commit       = bus_ack & pend_vld_q;
  assign pend_is_time = pend_addr_q < ADDR_W'(TIME_BYTES);
  assign ptr_is_time  = ptr_q < ADDR_W'(TIME_BYTES);
  assign core_wr_en   = commit & pend_is_time;
  assign core_wr_idx  = pend_addr_q[TIDX_W-1:0];
  assign core_wr_data = pend_data_q;
  assign div_clr      = core_wr_en & (pend_addr_q == '0);
  assign buf_we       = bus_wr & ptr_is_time;

  always_comb begin
    ptr_d       = ptr_q;
    pend_vld_d  = pend_vld_q;
    pend_addr_d = pend_addr_q;
    pend_data_d = pend_data_q;
    if (bus_addr_vld)          ptr_d = bus_addr;
    else if (bus_rd || commit) ptr_d = ptr_q + 1'b1;
    if (bus_start) pend_vld_d = 1'b0;
    else if (bus_wr) begin
      pend_vld_d  = 1'b1;
      pend_addr_d = ptr_q;
      pend_data_d = bus_wdata;
    end else if (commit) pend_vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q       <= '0;
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      ptr_q       <= ptr_d;
      pend_vld_q  <= pend_vld_d;
      pend_addr_q <= pend_addr_d;
      pend_data_q <= pend_data_d;
    end
  end

  rtc_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .clr(div_clr),
    .tick(sec_tick), .cnt_o(div_cnt)
  );

  rtc_shadow u_buf (
    .clk(clk), .rst_n(rst_n), .snap(bus_start), .live(core_time),
    .wr_en(buf_we), .wr_idx(ptr_q[TIDX_W-1:0]), .wr_data(bus_wdata),
    .rd_idx(ptr_q[TIDX_W-1:0]), .rd_data(buf_rd), .buf_o(shad_flat)
  );

  rtc_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(commit & ~pend_is_time),
    .wr_addr(pend_addr_q), .wr_data(pend_data_q),
    .rd_addr(ptr_q), .rd_data(store_rd)
  );

  assign bus_rdata = ptr_is_time ? buf_rd : store_rd;
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
  parameter int DIV_W  = 15,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_start,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_addr_vld,
  input logic              bus_ack,
  input logic [7:0]        bus_rdata,
  input logic              core_wr_en,
  input logic [2:0]        core_wr_idx,
  input logic              sec_tick,
  input logic [ADDR_W-1:0] ptr_q,
  input logic [55:0]       shad_flat,
  input logic [DIV_W-1:0]  div_cnt
);
  p_commit_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_en |-> bus_ack);

  p_div_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_en && core_wr_idx == 3'd0) |=> (div_cnt == '0));

  p_tick_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_en && core_wr_idx == 3'd0) |-> !sec_tick);

  p_ctrl_zero_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == ADDR_W'(7)) |-> ((bus_rdata & 8'h6C) == 8'h00));

  p_read_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr_vld) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));

  p_buffer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_start && !bus_wr) |=> $stable(shad_flat));
endmodule

bind rtc_regfile rtc_regfile_chk #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_addr_vld(bus_addr_vld), .bus_ack(bus_ack),
  .bus_rdata(bus_rdata), .core_wr_en(core_wr_en), .core_wr_idx(core_wr_idx),
  .sec_tick(sec_tick), .ptr_q(ptr_q), .shad_flat(shad_flat), .div_cnt(div_cnt)
);

// File: tb/rtc_regfile_test.sv
`timescale 1ns/1ps
module rtc_regfile_test;
  localparam int DIVW = 4;
  localparam int DIVN = 1 << DIVW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_en = 1'b0, bus_start = 1'b0, bus_addr_vld = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_ack = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [55:0] core_time = '0;
  logic core_wr_en, sec_tick;
  logic [2:0] core_wr_idx;
  logic [7:0] core_wr_data;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_regfile #(.DIV_W(DIVW), .ADDR_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bus_start(bus_start),
    .bus_addr_vld(bus_addr_vld), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .core_time(core_time), .core_wr_en(core_wr_en),
    .core_wr_idx(core_wr_idx), .core_wr_data(core_wr_data), .sec_tick(sec_tick)
  );

  // behavioural reference
  int m_ptr, m_pa, m_div;
  bit m_pv;
  logic [7:0] m_pd, m_ctrl;
  logic [7:0] m_sh [7];
  logic [7:0] m_ram [64];
  bit m_ramv [64];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_pa = 0; m_div = 0; m_pv = 0; m_pd = 0; m_ctrl = 0;
      foreach (m_sh[i]) m_sh[i] = 0;
      foreach (m_ramv[i]) m_ramv[i] = 0;
    end else begin
      bit cm;
      cm = bus_ack && m_pv;
      if (cm && m_pa == 7) m_ctrl = m_pd & 8'h93;
      else if (cm && m_pa >= 8) begin m_ram[m_pa] = m_pd; m_ramv[m_pa] = 1; end
      if (cm && m_pa == 0) m_div = 0;
      else if (osc_en) m_div = (m_div + 1) % DIVN;
      if (bus_start) foreach (m_sh[i]) m_sh[i] = core_time[8*i +: 8];
      else if (bus_wr && m_ptr < 7) m_sh[m_ptr] = bus_wdata;
      if (bus_start) m_pv = 0;
      else if (bus_wr) begin m_pv = 1; m_pa = m_ptr; m_pd = bus_wdata; end
      else if (cm) m_pv = 0;
      if (bus_addr_vld) m_ptr = bus_addr;
      else if (bus_rd || cm) m_ptr = (m_ptr + 1) % 64;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ew, et;
      ew = bus_ack && m_pv && m_pa < 7;
      et = osc_en && (m_div == DIVN - 1) && !(bus_ack && m_pv && m_pa == 0);
      chk("R3 core_wr_en", {7'd0, core_wr_en}, {7'd0, ew});
      if (ew) begin
        chk("R3 core_wr_idx", {5'd0, core_wr_idx}, 8'(m_pa));
        chk("R3 core_wr_data", core_wr_data, m_pd);
      end
      chk("R4 R5 R6 sec_tick", {7'd0, sec_tick}, {7'd0, et});
      if (m_ptr < 7)       chk("R2 buffer read", bus_rdata, m_sh[m_ptr]);
      else if (m_ptr == 7) chk("R7 control read", bus_rdata, m_ctrl);
      else if (m_ramv[m_ptr]) chk("R8 storage read", bus_rdata, m_ram[m_ptr]);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic set_addr(input logic [5:0] a);
    bus_addr_vld = 1; bus_addr = a; step(); bus_addr_vld = 0;
  endtask
  task automatic wr_byte(input logic [7:0] d);
    bus_wr = 1; bus_wdata = d; step(); bus_wr = 0;
    bus_ack = 1; step(); bus_ack = 0;
  endtask
  task automatic rd_byte(output logic [7:0] d);
    d = bus_rdata; bus_rd = 1; step(); bus_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [55:0] snap;
    int n, ticks;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R1: reset state
    chk("R1 reset rdata", bus_rdata, 8'h00);
    chk("R1 reset wr_en", {7'd0, core_wr_en}, 8'h00);
    set_addr(6'h07);
    chk("R1 reset control", bus_rdata, 8'h00);
    osc_en = 1;

    // R2: snapshot frozen while core moves
    snap = {8'h24, 8'h02, 8'h28, 8'h03, 8'h12, 8'h34, 8'h59};
    core_time = snap;
    bus_start = 1; step(); bus_start = 0;
    core_time = {8'h25, 8'h03, 8'h01, 8'h04, 8'h13, 8'h35, 8'h00};
    set_addr(6'h00);
    for (int i = 0; i < 7; i++) begin
      rd_byte(d);
      chk("R2 snapshot byte", d, snap[8*i +: 8]);
    end

    // R3: write minutes, commit on ack only
    set_addr(6'h01);
    bus_wr = 1; bus_wdata = 8'h45; step(); bus_wr = 0;
    chk("R3 no commit before ack", {7'd0, core_wr_en}, 8'h00);
    chk("R3 buffer updated", bus_rdata, 8'h45);
    bus_ack = 1;
    @(negedge clk);
    chk("R3 commit strobe", {7'd0, core_wr_en}, 8'h01);
    chk("R3 commit index", {5'd0, core_wr_idx}, 8'h01);
    chk("R3 commit data", core_wr_data, 8'h45);
    @(posedge clk); #1 bus_ack = 0;

    // R11: ack with nothing pending
    bus_ack = 1;
    @(negedge clk);
    chk("R11 no commit", {7'd0, core_wr_en}, 8'h00);
    @(posedge clk); #1 bus_ack = 0;
    chk("R11 pointer kept (reads hours)", bus_rdata, snap[16 +: 8]);

    // R6: four ticks in 64 enabled cycles
    ticks = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); if (sec_tick) ticks++;
    end
    @(posedge clk); #1;
    chk("R6 tick count", 8'(ticks), 8'd4);

    // R5 + R4: seconds commit in the tick cycle
    set_addr(6'h00);
    bus_wr = 1; bus_wdata = 8'h30; step(); bus_wr = 0;
    while (m_div != DIVN - 1) step();
    bus_ack = 1;
    @(negedge clk);
    chk("R5 tick dropped", {7'd0, sec_tick}, 8'h00);
    chk("R4 seconds commit", {7'd0, core_wr_en}, 8'h01);
    @(posedge clk); #1 bus_ack = 0;
    n = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk); if (sec_tick && n == 0) n = i;
    end
    @(posedge clk); #1;
    chk("R4 cycles to next tick", 8'(n), 8'(DIVN));

    // R7: control mask
    set_addr(6'h07);
    wr_byte(8'hFF);
    set_addr(6'h07);
    chk("R7 control FF", bus_rdata, 8'h93);
    wr_byte(8'h6C);
    set_addr(6'h07);
    chk("R7 control 6C", bus_rdata, 8'h00);

    // R8 + R9 + R10: storage, auto-increment, wrap
    set_addr(6'h3E);
    wr_byte(8'hA5);
    wr_byte(8'h5A);
    chk("R9 wrap to 00 after write", bus_rdata, 8'h30);
    set_addr(6'h3E);
    chk("R10 pointer load", bus_rdata, 8'hA5);
    rd_byte(d);
    chk("R8 storage 3E", d, 8'hA5);
    rd_byte(d);
    chk("R8 storage 3F", d, 8'h5A);
    chk("R9 wrap to 00 after read", bus_rdata, 8'h30);
    set_addr(6'h08);
    wr_byte(8'h11);
    set_addr(6'h08);
    chk("R8 storage 08", bus_rdata, 8'h11);

    repeat (4) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule